// File: doc/BRIEF.md
# Dual-Source Clear/Hold Sequence Counter

This block is a small binary up-counter with two control functions, clear and hold. Each function has two request inputs. The block ORs the two requests of a function into one active signal. A clear forces the count to zero. A hold freezes the count at its present value. Clear always wins over hold. When neither function is active, the count advances by one and wraps around. Sequencers and waveform generators that derive timing from the count value use this block.

Each function has its own mode input. The mode picks one of two paths for that function's request:
- Direct path: the request acts on the very next active edge.
- Registered path: the request first passes through a one-stage pipeline register, so it acts one active edge later.

The pipeline register loads on every active edge, whichever mode is selected. A build-time parameter selects whether the rising or the falling clock edge is active. The reset is asynchronous and active low.

Top module: `seqctr_top`

## Requirements
- R1: While `rst_n` is low, `count` is 0, and both request pipelines hold an inactive value.
- R2: On an active edge where neither clear nor hold is in effect, `count` becomes `count + 1` modulo 64, so 63 is followed by 0.
- R3: With `clr_reg_mode` = 0, a high level on either bit of `clr_req` makes `count` 0 at the next active edge.
- R4: With `hold_reg_mode` = 0, a high level on either bit of `hold_req` (and no clear in effect) keeps `count` unchanged over the next active edge.
- R5: When a clear and a hold are in effect on the same active edge, `count` becomes 0.
- R6: With `clr_reg_mode` = 1, the clear in effect at an edge is the OR of `clr_req` sampled at the previous active edge. The `clr_req` value present at the current edge has no effect on that edge.
- R7: With `hold_reg_mode` = 1, the hold in effect at an edge is the OR of `hold_req` sampled at the previous active edge. The `hold_req` value present at the current edge has no effect on that edge.
- R8: With parameter `FALL_EDGE` = 0, all state changes on the rising edge of `clk`. With `FALL_EDGE` = 1, all state changes on the falling edge only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the active edge is selected by `FALL_EDGE` |
| rst_n | input | 1 | Asynchronous reset, active low |
| clr_req | input | 2 | Clear requests; the two bits are ORed |
| hold_req | input | 2 | Hold requests; the two bits are ORed |
| clr_reg_mode | input | 1 | 1 = clear goes through the pipeline register; 0 = direct |
| hold_reg_mode | input | 1 | 1 = hold goes through the pipeline register; 0 = direct |
| count | output | 6 | Present count value |

## Verification
Two instances are driven by one stimulus stream: one is active on the rising edge and one on the falling edge. The stimulus runs through all four mode combinations in sequence, without a reset between them.

The request patterns are pseudo-random, with these properties:
- Clear and hold are sparse.
- Each source bit is asserted both alone and together with its partner, so the OR of the two sources is exercised.
- Clear and hold sometimes coincide, which tests priority.
- In registered mode, requests that last a single cycle separate the one-edge delay from the direct timing.

A long request-free stretch carries the count through the 63-to-0 wrap. Checking between the rising and falling edges shows which instance has moved, which confirms that each instance reacts only to its selected edge.

// File: rtl/seqctr_pkg.sv
package seqctr_pkg;

    // Action resolved for one active edge, listed in priority order
    typedef enum logic [1:0] {
        ACT_COUNT = 2'd0,
        ACT_HOLD  = 2'd1,
        ACT_CLEAR = 2'd2
    } ctr_act_e;

    function automatic ctr_act_e resolve_act(input logic clr, input logic hold);
        if (clr)       return ACT_CLEAR;
        else if (hold) return ACT_HOLD;
        else           return ACT_COUNT;
    endfunction

endpackage

// File: rtl/seqctr_req_path.sv
module seqctr_req_path #(
    parameter int NSRC = 2
) (
    input  logic            clk_act,
    input  logic            rst_n,
    input  logic [NSRC-1:0] req,
    input  logic            reg_mode,
    output logic            active
);

    typedef struct packed {
        logic pipe;
    } path_st_t;

    path_st_t st_d, st_q;
    logic     req_any;

    always_comb begin
        req_any     = |req;
        st_d.pipe   = req_any;
        active      = reg_mode ? st_q.pipe : req_any;
    end

    always_ff @(posedge clk_act or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

endmodule

// File: rtl/seqctr_core.sv
module seqctr_core
    import seqctr_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk_act,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             hold,
    output logic [CNT_W-1:0] count
);

    typedef struct packed {
        logic [CNT_W-1:0] count;
    } core_st_t;

    core_st_t st_d, st_q;
    ctr_act_e act;

    always_comb begin
        act  = resolve_act(clr, hold);
        st_d = st_q;
        unique case (act)
            ACT_CLEAR: st_d.count = '0;
            ACT_HOLD:  st_d.count = st_q.count;
            default:   st_d.count = st_q.count + 1'b1;
        endcase
    end

    always_ff @(posedge clk_act or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign count = st_q.count;

endmodule

// File: rtl/seqctr_top.sv
module seqctr_top #(
    parameter int CNT_W     = 6,
    parameter int NSRC      = 2,
    parameter bit FALL_EDGE = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NSRC-1:0]  clr_req,
    input  logic [NSRC-1:0]  hold_req,
    input  logic             clr_reg_mode,
    input  logic             hold_reg_mode,
    output logic [CNT_W-1:0] count
);

    logic clk_act;
    logic clr_eff;
    logic hold_eff;

    generate
        if (FALL_EDGE) begin : g_fall
            assign clk_act = ~clk;
        end else begin : g_rise
            assign clk_act = clk;
        end
    endgenerate

    seqctr_req_path #(.NSRC(NSRC)) i_clr_path (
        .clk_act  (clk_act),
        .rst_n    (rst_n),
        .req      (clr_req),
        .reg_mode (clr_reg_mode),
        .active   (clr_eff)
    );

    seqctr_req_path #(.NSRC(NSRC)) i_hold_path (
        .clk_act  (clk_act),
        .rst_n    (rst_n),
        .req      (hold_req),
        .reg_mode (hold_reg_mode),
        .active   (hold_eff)
    );

    seqctr_core #(.CNT_W(CNT_W)) i_core (
        .clk_act (clk_act),
        .rst_n   (rst_n),
        .clr     (clr_eff),
        .hold    (hold_eff),
        .count   (count)
    );

endmodule

// File: rtl/seqctr_chk.sv
module seqctr_chk #(
    parameter int CNT_W = 6,
    parameter int NSRC  = 2
) (
    input logic             clk_act,
    input logic             rst_n,
    input logic [NSRC-1:0]  clr_req,
    input logic [NSRC-1:0]  hold_req,
    input logic             clr_reg_mode,
    input logic             hold_reg_mode,
    input logic [CNT_W-1:0] count
);

    always_comb begin
        if (!rst_n) begin
            a_r1_reset_zero: assert (count == '0);
        end
    end

    a_r2_increment: assert property (@(posedge clk_act) disable iff (!rst_n)
        (!clr_reg_mode && !hold_reg_mode && !(|clr_req) && !(|hold_req))
        |=> count == CNT_W'($past(count) + 1'b1));

    a_r3_clear_direct: assert property (@(posedge clk_act) disable iff (!rst_n)
        (!clr_reg_mode && |clr_req) |=> count == '0);

    a_r4_hold_direct: assert property (@(posedge clk_act) disable iff (!rst_n)
        (!hold_reg_mode && |hold_req && !clr_reg_mode && !(|clr_req))
        |=> count == $past(count));

    a_r5_clear_wins: assert property (@(posedge clk_act) disable iff (!rst_n)
        (!clr_reg_mode && |clr_req && !hold_reg_mode && |hold_req)
        |=> count == '0);

    a_r6_clear_delayed: assert property (@(posedge clk_act) disable iff (!rst_n)
        (clr_reg_mode && |clr_req) ##1 clr_reg_mode |=> count == '0);

    a_r7_hold_delayed: assert property (@(posedge clk_act) disable iff (!rst_n)
        (hold_reg_mode && |hold_req) ##1 (hold_reg_mode && !clr_reg_mode && !(|clr_req))
        |=> count == $past(count));

endmodule

bind seqctr_top seqctr_chk #(.CNT_W(CNT_W), .NSRC(NSRC)) i_seqctr_chk (
    .clk_act       (clk_act),
    .rst_n         (rst_n),
    .clr_req       (clr_req),
    .hold_req      (hold_req),
    .clr_reg_mode  (clr_reg_mode),
    .hold_reg_mode (hold_reg_mode),
    .count         (count)
);

// File: tb/test_seqctr_top.sv
`timescale 1ns/1ps
module test_seqctr_top;

    localparam int CNT_W = 6;
    localparam int NSRC  = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NSRC-1:0]  clr_req = '0;
    logic [NSRC-1:0]  hold_req = '0;
    logic             clr_reg_mode = 1'b0;
    logic             hold_reg_mode = 1'b0;
    logic [CNT_W-1:0] count_r;
    logic [CNT_W-1:0] count_f;

    int n_cmp = 0;
    int n_bad = 0;

    logic [CNT_W-1:0] exp_q = '0;
    logic             mpc = 1'b0;
    logic             mph = 1'b0;
    logic [7:0]       lfsr = 8'h5a;

    always #2 clk = ~clk;

    seqctr_top #(.CNT_W(CNT_W), .NSRC(NSRC), .FALL_EDGE(1'b0)) i_seqctr_top (
        .clk(clk), .rst_n(rst_n), .clr_req(clr_req), .hold_req(hold_req),
        .clr_reg_mode(clr_reg_mode), .hold_reg_mode(hold_reg_mode), .count(count_r)
    );

    seqctr_top #(.CNT_W(CNT_W), .NSRC(NSRC), .FALL_EDGE(1'b1)) i_seqctr_top_fall (
        .clk(clk), .rst_n(rst_n), .clr_req(clr_req), .hold_req(hold_req),
        .clr_reg_mode(clr_reg_mode), .hold_reg_mode(hold_reg_mode), .count(count_f)
    );

    task automatic check(input string req, input logic [CNT_W-1:0] act,
                         input logic [CNT_W-1:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // Called at negedge+1: drive, model one active edge, check both instances
    task automatic step(input logic [NSRC-1:0] c, input logic [NSRC-1:0] h);
        logic ec, eh;
        logic [CNT_W-1:0] nxt;
        string tag;
        clr_req  = c;
        hold_req = h;
        ec = clr_reg_mode  ? mpc : |c;
        eh = hold_reg_mode ? mph : |h;
        if (ec)      nxt = '0;
        else if (eh) nxt = exp_q;
        else         nxt = exp_q + 1'b1;
        if (ec)      tag = clr_reg_mode ? "R6" : (eh ? "R5" : "R3");
        else if (eh) tag = hold_reg_mode ? "R7" : "R4";
        else         tag = "R2";
        mpc = |c;
        mph = |h;
        @(posedge clk); #1;
        check(tag, count_r, nxt);
        check("R8 falling unchanged at rise", count_f, exp_q);
        @(negedge clk); #1;
        check(tag, count_f, nxt);
        check("R8 rising unchanged at fall", count_r, nxt);
        exp_q = nxt;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [NSRC-1:0] c, h;
        repeat (3) @(negedge clk);
        #1;
        check("R1 reset rise", count_r, '0);
        check("R1 reset fall", count_f, '0);
        rst_n = 1'b1;

        // R2: free run through the wrap
        for (int i = 0; i < 70; i++) step('0, '0);

        // Directed: each source alone, R3/R4, then coincidence R5
        step(2'b01, 2'b00);
        step(2'b00, 2'b00);
        step(2'b10, 2'b00);
        step(2'b00, 2'b00);
        step(2'b00, 2'b01);
        step(2'b00, 2'b10);
        step(2'b11, 2'b11);

        // Sweep all mode combinations with pseudo-random requests
        for (int m = 0; m < 4; m++) begin
            clr_reg_mode  = m[0];
            hold_reg_mode = m[1];
            for (int i = 0; i < 300; i++) begin
                lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
                c = (lfsr[2:0] == 3'd0) ? ((lfsr[4:3] == 2'b00) ? 2'b01 : lfsr[4:3]) : 2'b00;
                h = (lfsr[6] & lfsr[5]) ? {lfsr[7], lfsr[0]} : 2'b00;
                step(c, h);
            end
            // single-cycle request then quiet: delayed action in registered mode (R6/R7)
            step(2'b10, 2'b00);
            step(2'b00, 2'b00);
            step(2'b00, 2'b00);
            step(2'b00, 2'b01);
            step(2'b00, 2'b00);
            step(2'b00, 2'b00);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule